// File: doc/BRIEF.md
# Register-Exchange Survivor Memory with Output Decision

This block is the path memory and output stage of a four-state (constraint length 3) trellis decoder. Each state owns a survivor register of `W` bits. On each accepted step, the add-compare-select array supplies one decision bit per state and the current path metrics. Every state register is then reloaded, all at once, from the register of the predecessor that its decision bit names. The information bit that enters that state is appended at the newest end. Because whole histories are exchanged, no traceback pass is needed. The decoded bit for time t−W is the oldest bit of one chosen register.

The chosen register comes from one of two sources, picked by the plain control pin `pick_best` and sampled with the step. The first is the state holding the largest path metric, found by a winner-take-all comparison. The second is the fixed state `FIXED_STATE`. Steps arrive on a valid/ready input stream and decoded bits leave on a valid/ready output stream. There is a single output register and no further buffering, so back-pressure at the output stalls the input directly.

Top module: `rex_survivor_mem`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, every survivor register holds zeros and the count of accepted steps is zero.
- R2: A step is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly when `out_valid` is 1 and `out_ready` is 0.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` keeps its value.
- R4: `out_valid` first rises on the edge that accepts the W-th step after reset. No decoded bit is presented before that.
- R5: On an accepted step, state n (bits n[1:0]) takes the register of predecessor p = {n[0], in_dec[n]}. That register is shifted one place toward the oldest end, and n[1] is appended as the newest bit.
- R6: The output is the oldest bit of the selected register after the update by the accepting step. It is registered on that same edge.
- R7: When `pick_best` is 1, the selected state has the largest metric. Metric of state i is the unsigned field `in_metric[i*MW +: MW]`. A tie goes to the lowest state index.
- R8: When `pick_best` is 0, the selected state is `FIXED_STATE`, whatever the metrics are.
- R9: Survivor registers do not change on a cycle with no accepted step. When a decoded bit is taken and no step is accepted in the same cycle, `out_valid` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Step available |
| in_ready | output | 1 | Step can be accepted |
| in_dec | input | NS | Decision bit per state (selects predecessor) |
| in_metric | input | NS*MW | Path metrics, state i in bits i*MW +: MW, unsigned, larger is better |
| pick_best | input | 1 | 1: largest-metric state, 0: fixed state |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded information bit for time t−W |

## Verification
The bench builds the block with W = 5, MW = 4 and FIXED_STATE = 2. The short depth means the first decoded bit, and many exchanged histories after it, fall within a few hundred steps. The narrow metrics let a near-exhaustive sweep cover every combination of 2-bit metric values across the four states, which reaches every tie pattern of the winner selection. All 16 decision vectors are driven in both selection modes, against a bench model of the exchange rule. Stalls, output back-pressure and a reset in mid-stream are also exercised.

// File: rtl/rex_pkg.sv
package rex_pkg;
  // How the output register is chosen
  typedef enum logic {
    SEL_FIXED = 1'b0,
    SEL_BEST  = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/rex_state_bank.sv
module rex_state_bank #(
  parameter int NS = 4,
  parameter int W  = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic [NS-1:0]         dec,
  output logic [NS-1:0][W-1:0]  cur_o,
  output logic [NS-1:0][W-1:0]  nxt_o
);
  localparam int M = $clog2(NS);

  logic [NS-1:0][W-1:0] regs_q;

  for (genvar n = 0; n < NS; n++) begin : g_state
    localparam logic [M-1:0] PBASE  = M'((2 * n) % NS);
    localparam logic         NEWBIT = 1'(n / (NS / 2));
    logic [M-1:0] pidx;
    assign pidx     = PBASE | {{(M-1){1'b0}}, dec[n]};
    assign nxt_o[n] = {regs_q[pidx][W-2:0], NEWBIT};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else if (step) regs_q <= nxt_o;
  end

  assign cur_o = regs_q;

  // R9: registers hold when no step is accepted
  a_r9_hold_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(regs_q));
endmodule

// File: rtl/rex_best_select.sv
module rex_best_select #(
  parameter int NS = 4,
  parameter int MW = 8
) (
  input  logic [NS-1:0][MW-1:0]  metric,
  output logic [$clog2(NS)-1:0]  win_o
);
  localparam int M = $clog2(NS);

  always_comb begin
    win_o = '0;
    for (int i = 1; i < NS; i++) begin
      if (metric[i] > metric[win_o]) win_o = M'(i);
    end
  end
endmodule

// File: rtl/rex_survivor_mem.sv
module rex_survivor_mem #(
  parameter int NS          = 4,
  parameter int W           = 15,
  parameter int MW          = 8,
  parameter int FIXED_STATE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NS-1:0]     in_dec,
  input  logic [NS*MW-1:0]  in_metric,
  input  logic              pick_best,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit
);
  import rex_pkg::*;

  localparam int M  = $clog2(NS);
  localparam int CW = $clog2(W + 1);

  logic [NS-1:0][MW-1:0] met;
  logic [NS-1:0][W-1:0]  cur_regs, nxt_regs;
  logic [M-1:0]          win, sel;
  logic [CW-1:0]         cnt_q;
  logic                  accept, warm;
  sel_mode_e             mode;

  assign met      = in_metric;
  assign mode     = sel_mode_e'(pick_best);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign warm     = (cnt_q >= CW'(W - 1));

  rex_state_bank #(.NS(NS), .W(W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (accept),
    .dec   (in_dec),
    .cur_o (cur_regs),
    .nxt_o (nxt_regs)
  );

  rex_best_select #(.NS(NS), .MW(MW)) u_sel (
    .metric (met),
    .win_o  (win)
  );

  assign sel = (mode == SEL_BEST) ? win : M'(FIXED_STATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (accept && !warm) cnt_q <= cnt_q + 1'b1;
      else if (accept)     cnt_q <= CW'(W);
      if (accept && warm) begin
        out_valid <= 1'b1;
        out_bit   <= nxt_regs[sel][W-1];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R3: held output under back-pressure
  a_r3_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R4: no decoded bit before W steps
  a_r4_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_q == CW'(W)));

  // R9: taken output with no new step empties the stage
  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !accept) |=> !out_valid);

  // R7: winner holds the largest metric, ties to lowest index
  for (genvar gi = 0; gi < NS; gi++) begin : g_chk
    localparam logic [M-1:0] GI = M'(gi);
    a_r7_best_max: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pick_best) |->
        ((met[gi] <= met[win]) && ((GI >= win) || (met[gi] < met[win]))));
  end
endmodule

// File: tb/rex_survivor_mem_tb.sv
`timescale 1ns/1ps
module rex_survivor_mem_tb;
  localparam int NS = 4;
  localparam int W  = 5;
  localparam int MW = 4;
  localparam int FS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [NS-1:0] in_dec = '0;
  logic [NS*MW-1:0] in_metric = '0;
  logic pick_best = 1'b1;
  logic out_valid, out_ready = 1'b1, out_bit;

  int checks = 0, errors = 0;
  logic [W-1:0] mr [NS];
  int mcnt = 0;
  logic exp_bit = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  rex_survivor_mem #(.NS(NS), .W(W), .MW(MW), .FIXED_STATE(FS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dec(in_dec), .in_metric(in_metric), .pick_best(pick_best),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit));

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  function automatic int best_of(input logic [NS*MW-1:0] m);
    int b = 0;
    for (int i = 1; i < NS; i++)
      if (m[i*MW +: MW] > m[b*MW +: MW]) b = i;
    return b;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NS; i++) mr[i] = '0;
    mcnt = 0;
  endtask

  // Drives one step from a negedge, ends at the next negedge with outputs checked
  task automatic step(input logic [NS-1:0] d, input logic [NS*MW-1:0] m,
                      input logic pb, input string req);
    logic [W-1:0] nr [NS];
    int s;
    logic acc;
    in_dec = d; in_metric = m; pick_best = pb; in_valid = 1'b1;
    #1 acc = in_ready;
    @(posedge clk);
    if (acc) begin
      for (int n = 0; n < NS; n++) begin
        int p = ((2 * n) % NS) + int'(d[n]);
        nr[n] = {mr[p][W-2:0], 1'(n / (NS / 2))};
      end
      for (int n = 0; n < NS; n++) mr[n] = nr[n];
      if (mcnt < W) mcnt++;
      s = pb ? best_of(m) : FS;
      if (mcnt == W) exp_bit = mr[s][W-1];
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid, (mcnt == W), {req, " valid"});
    if (mcnt == W) chk(out_bit, exp_bit, req);
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid, 1'b0, "R1");
    chk(in_ready, 1'b1, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid, 1'b0, "R1");

    // R4 + R5 + R6: warm-up then all decision vectors, best mode
    for (int k = 0; k < 64; k++) begin
      lfsr = nxt(lfsr);
      step(4'(k), {lfsr[11:0], lfsr[15:12]}, 1'b1, (k < W) ? "R4" : "R5");
    end
    // R8: fixed mode, decisions sweep, metrics must not matter
    for (int k = 0; k < 64; k++) begin
      lfsr = nxt(lfsr);
      step(lfsr[3:0] ^ 4'(k), lfsr, 1'b0, "R8");
    end
    // R7: exhaustive 2-bit metric patterns with ties
    for (int k = 0; k < 256; k++) begin
      logic [NS*MW-1:0] m;
      for (int i = 0; i < NS; i++) m[i*MW +: MW] = MW'((k >> (2 * i)) & 3);
      lfsr = nxt(lfsr);
      step(lfsr[3:0], m, 1'b1, "R7");
    end

    // R2 + R3: back-pressure
    out_ready = 1'b0;
    begin
      logic held;
      held = out_bit;
      in_valid = 1'b1; in_dec = 4'hF;
      #1 chk(in_ready, 1'b0, "R2");
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chk(out_valid, 1'b1, "R3");
        chk(out_bit, held, "R3");
      end
      in_valid = 1'b0;
    end
    out_ready = 1'b1;
    #1 chk(in_ready, 1'b1, "R2");
    // R9: drain with no step, then registers unchanged after idle cycles
    @(negedge clk);
    chk(out_valid, 1'b0, "R9");
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      lfsr = nxt(lfsr);
      step(lfsr[7:4], lfsr, lfsr[0], "R9");
    end
    // R2: stall with out_ready low, then same step accepted later
    out_ready = 1'b0;
    @(negedge clk);
    lfsr = nxt(lfsr);
    step(lfsr[3:0], lfsr, 1'b1, "R2");
    out_ready = 1'b1;
    step(lfsr[7:4], lfsr, 1'b1, "R2");

    // R1: reset mid-stream, warm-up repeats
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid, 1'b0, "R1");
    chk(in_ready, 1'b1, "R1");
    rst_n = 1'b1;
    model_clear();
    for (int k = 0; k < 3 * W; k++) begin
      lfsr = nxt(lfsr);
      step(lfsr[3:0], lfsr, 1'b0, "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule